// File: doc/BRIEF.md
# Multiplexed Host Register Bus Slave

This block lets a host reach a small set of on-chip registers through a narrow parallel port. The port consists of eight shared address/data lines and a few control pins. Every host access is a strobe framed by an active-low chip select. A select line chooses between two kinds of strobe. With the select line high, a write strobe loads the value on the shared lines into an address latch. With it low, a write or read strobe moves one byte to or from the register that the latch names. The block drives an active-low ready pin back to the host when each access has completed. It drives the shared lines only while the host is reading data.

All host-side controls are asynchronous to the block clock and pass through a short synchroniser. On the chip side, the block presents a plain register port to the neighbouring logic: an address, a one-cycle write enable with write data, and a one-cycle read enable with read data. The block decodes which addresses exist. It answers the revision address with a constant of its own, and it answers every unmapped address with zero. The block also carries an active-low interrupt line out to the host and brings the host's active-low reset for the attached circuitry in through the same synchroniser.

Top module: `hbs_slave`

## Requirements
- R1: During and directly after reset, hb_rdy_n and hb_int_n are 1, periph_rst is 0, reg_wr_en and reg_rd_en are 0, and the block does not drive hb_data.
- R2: A write strobe (hb_wr_n low, then high) with hb_cs_n low and hb_sel = 1 loads the hb_data byte into the address latch, shown on reg_addr. It raises no reg_wr_en.
- R3: A write strobe with hb_cs_n low and hb_sel = 0 to a writable address raises reg_wr_en for exactly one cycle. In that cycle reg_addr holds the latched address and reg_wdata holds the byte the host drove. The writable addresses are 0x00, 0x01, 0x04 through 0x0A, 0x0C and 0x0D.
- R4: A data-phase write to 0x0F or to any unmapped address raises no reg_wr_en and changes no register, but it is still acknowledged on hb_rdy_n.
- R5: A read strobe with hb_cs_n low and hb_sel = 0 at a writable address raises reg_rd_en for exactly one cycle. The host then sees the reg_rdata value of that cycle.
- R6: A read at address 0x0F returns the REVISION parameter and raises no reg_rd_en.
- R7: A read at any unmapped address returns 0x00 and raises no reg_rd_en.
- R8: Each completed access (an address write, a data write or a data read) pulls hb_rdy_n low for exactly one clock cycle. During a read, the returned byte is already on hb_data while hb_rdy_n is low.
- R9: The block drives hb_data only while the synchronised hb_cs_n, hb_rd_n and hb_sel are all low. A read strobe with hb_sel = 1 leaves the bus undriven, gives no ready pulse and leaves the address latch unchanged.
- R10: Strobes given while hb_cs_n is high are ignored: no ready pulse, no register access, and no change to the address latch.
- R11: hb_int_n is the inverse of irq_req, delayed by one clock register.
- R12: periph_rst is the inverse of hb_rst_n after passing through the synchroniser.
- R13: The latched address persists across any number of data-phase accesses, so repeated writes and reads reach the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| hb_cs_n | input | 1 | Host chip select, active low |
| hb_wr_n | input | 1 | Host write strobe, active low |
| hb_rd_n | input | 1 | Host read strobe, active low |
| hb_sel | input | 1 | 1 = address phase, 0 = data phase |
| hb_data | inout | 8 | Shared address/data lines |
| hb_rdy_n | output | 1 | Access complete, active low, one cycle |
| hb_int_n | output | 1 | Interrupt to host, active low |
| hb_rst_n | input | 1 | Host reset for attached circuitry, active low |
| irq_req | input | 1 | Interrupt request from the chip, active high |
| periph_rst | output | 1 | Synchronised reset for attached circuitry, active high |
| reg_addr | output | 8 | Latched register address |
| reg_wr_en | output | 1 | One-cycle register write enable |
| reg_wdata | output | 8 | Register write data |
| reg_rd_en | output | 1 | One-cycle register read enable |
| reg_rdata | input | 8 | Register read data, valid while reg_rd_en is high |

## Verification
The bench builds the block with its default parameters: an 8-bit bus, a two-flop synchroniser and REVISION = 0x2A. At that size the whole address space has only 256 values. The bench therefore latches every address in turn, writes a pattern derived from the address, and reads it back. This covers the full decode of writable, revision and unmapped addresses on both the write and the read path. Directed sequences then cover bursts at one latched address, strobes with chip select high, address-phase reads, and the interrupt and reset pass-through.

// File: rtl/hbs_pkg.sv
package hbs_pkg;

    localparam int unsigned BUS_W      = 8;
    localparam int unsigned SYNC_DEPTH = 2;

    typedef logic [BUS_W-1:0] bus_t;

    localparam bus_t REV_ADDR = bus_t'(15);

    // Synchronised host control group
    typedef struct packed {
        logic cs_n;
        logic wr_n;
        logic rd_n;
        logic sel;
        logic rst_n;
    } ctl_t;

    localparam int unsigned CTL_W = $bits(ctl_t);

    localparam ctl_t CTL_IDLE = '{cs_n: 1'b1, wr_n: 1'b1, rd_n: 1'b1,
                                  sel: 1'b0, rst_n: 1'b1};

    // Values held while a write strobe is low
    typedef struct packed {
        bus_t data;
        logic sel;
        logic cs_ok;
    } wr_cap_t;

    typedef enum logic [1:0] {
        CMT_NONE,
        CMT_ADDR,
        CMT_DATA
    } commit_e;

    // Addresses backed by neighbour registers (revision excluded)
    function automatic logic reg_writable(input bus_t a);
        return int'(a) inside {0, 1, [4:10], 12, 13};
    endfunction

endpackage

// File: rtl/hbs_sync.sv
module hbs_sync #(
    parameter int unsigned W       = 1,
    parameter int unsigned STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= RST_VAL;
                    else     stg[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= RST_VAL;
                    else     stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/hbs_wr_phase.sv
module hbs_wr_phase
    import hbs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cs_n_s,
    input  logic wr_n_s,
    input  logic sel_s,
    input  bus_t bus_in,
    output bus_t addr_q,
    output logic reg_wr_en,
    output bus_t reg_wdata,
    output logic wr_done
);

    logic    wr_prev;
    wr_cap_t cap;
    commit_e cmt;

    always_comb begin
        cmt = CMT_NONE;
        if (wr_n_s && !wr_prev && cap.cs_ok)
            cmt = cap.sel ? CMT_ADDR : CMT_DATA;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_prev   <= 1'b1;
            cap       <= '0;
            addr_q    <= '0;
            reg_wr_en <= 1'b0;
            reg_wdata <= '0;
            wr_done   <= 1'b0;
        end else begin
            wr_prev <= wr_n_s;
            if (!wr_n_s)
                cap <= '{data: bus_in, sel: sel_s, cs_ok: !cs_n_s};
            wr_done   <= (cmt != CMT_NONE);
            reg_wr_en <= (cmt == CMT_DATA) && reg_writable(addr_q);
            if (cmt == CMT_ADDR) addr_q    <= cap.data;
            if (cmt == CMT_DATA) reg_wdata <= cap.data;
        end
    end

    AST_WR_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |=> !reg_wr_en); // R3
    AST_NO_REV_WRITE: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |-> (addr_q != REV_ADDR)); // R4
    AST_ADDR_HELD_ON_DATA: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |-> $stable(addr_q)); // R13

endmodule

// File: rtl/hbs_rd_path.sv
module hbs_rd_path
    import hbs_pkg::*;
#(
    parameter bus_t REVISION = bus_t'(8'h2A)
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n_s,
    input  logic rd_n_s,
    input  logic sel_s,
    input  bus_t addr,
    input  bus_t reg_rdata,
    output logic reg_rd_en,
    output logic rd_done,
    output bus_t rd_data_q,
    output logic drive_en
);

    logic rd_prev;
    logic pend;
    logic rd_start;
    bus_t rd_mux;

    assign rd_start = !rd_n_s && rd_prev && !cs_n_s && !sel_s;
    assign drive_en = !cs_n_s && !rd_n_s && !sel_s;

    always_comb begin
        if (addr == REV_ADDR)       rd_mux = REVISION;
        else if (reg_writable(addr)) rd_mux = reg_rdata;
        else                        rd_mux = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_prev   <= 1'b1;
            pend      <= 1'b0;
            reg_rd_en <= 1'b0;
            rd_done   <= 1'b0;
            rd_data_q <= '0;
        end else begin
            rd_prev   <= rd_n_s;
            pend      <= rd_start;
            reg_rd_en <= rd_start && reg_writable(addr);
            rd_done   <= pend;
            if (pend) rd_data_q <= rd_mux;
        end
    end

    AST_RD_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        reg_rd_en |=> !reg_rd_en); // R5
    AST_RD_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        reg_rd_en |=> rd_done); // R5
    AST_REV_NO_FETCH: assert property (@(posedge clk) disable iff (rst)
        reg_rd_en |-> (addr != REV_ADDR)); // R6

endmodule

// File: rtl/hbs_slave.sv
module hbs_slave
    import hbs_pkg::*;
#(
    parameter bus_t        REVISION    = bus_t'(8'h2A),
    parameter int unsigned SYNC_STAGES = SYNC_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hb_cs_n,
    input  logic             hb_wr_n,
    input  logic             hb_rd_n,
    input  logic             hb_sel,
    inout  wire  [BUS_W-1:0] hb_data,
    output logic             hb_rdy_n,
    output logic             hb_int_n,
    input  logic             hb_rst_n,
    input  logic             irq_req,
    output logic             periph_rst,
    output logic [BUS_W-1:0] reg_addr,
    output logic             reg_wr_en,
    output logic [BUS_W-1:0] reg_wdata,
    output logic             reg_rd_en,
    input  logic [BUS_W-1:0] reg_rdata
);

    ctl_t             ctl_raw;
    ctl_t             ctl_s;
    logic [CTL_W-1:0] ctl_q;
    bus_t             rd_data_q;
    logic             drive_en;
    logic             wr_done;
    logic             rd_done;

    assign ctl_raw = '{cs_n: hb_cs_n, wr_n: hb_wr_n, rd_n: hb_rd_n,
                       sel: hb_sel, rst_n: hb_rst_n};

    hbs_sync #(
        .W       (CTL_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (CTL_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ctl_raw),
        .q   (ctl_q)
    );

    assign ctl_s = ctl_t'(ctl_q);

    hbs_wr_phase u_wr (
        .clk       (clk),
        .rst       (rst),
        .cs_n_s    (ctl_s.cs_n),
        .wr_n_s    (ctl_s.wr_n),
        .sel_s     (ctl_s.sel),
        .bus_in    (hb_data),
        .addr_q    (reg_addr),
        .reg_wr_en (reg_wr_en),
        .reg_wdata (reg_wdata),
        .wr_done   (wr_done)
    );

    hbs_rd_path #(
        .REVISION (REVISION)
    ) u_rd (
        .clk       (clk),
        .rst       (rst),
        .cs_n_s    (ctl_s.cs_n),
        .rd_n_s    (ctl_s.rd_n),
        .sel_s     (ctl_s.sel),
        .addr      (reg_addr),
        .reg_rdata (reg_rdata),
        .reg_rd_en (reg_rd_en),
        .rd_done   (rd_done),
        .rd_data_q (rd_data_q),
        .drive_en  (drive_en)
    );

    assign hb_data    = drive_en ? rd_data_q : 'z;
    assign periph_rst = !ctl_s.rst_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            hb_rdy_n <= 1'b1;
            hb_int_n <= 1'b1;
        end else begin
            hb_rdy_n <= !(wr_done || rd_done);
            hb_int_n <= !irq_req;
        end
    end

    AST_RDY_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        !hb_rdy_n |=> hb_rdy_n); // R8
    AST_WRITE_ACKED: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |=> !hb_rdy_n); // R8
    AST_READ_ACKED: assert property (@(posedge clk) disable iff (rst)
        reg_rd_en |-> ##2 !hb_rdy_n); // R5

endmodule

// File: tb/tb_hbs_slave.sv
module tb_hbs_slave;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] REV = 8'h2A;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hb_cs_n = 1'b1, hb_wr_n = 1'b1, hb_rd_n = 1'b1, hb_sel = 1'b0;
    logic       hb_rst_n = 1'b1, irq_req = 1'b0;
    logic [7:0] drv = 8'h00;
    logic       drv_en = 1'b0;
    wire  [7:0] hb_data;
    logic       hb_rdy_n, hb_int_n, periph_rst;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic       reg_wr_en, reg_rd_en;

    logic [7:0] tbmem [16];
    int         wr_cnt = 0, rd_cnt = 0;
    logic [7:0] last_wa = 8'h00, last_wd = 8'h00;
    int         checks = 0, fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign hb_data = drv_en ? drv : 8'bz;
    for (genvar i = 0; i < 8; i++) begin : g_pu
        pullup (hb_data[i]);
    end

    assign reg_rdata = tbmem[reg_addr[3:0]];

    always @(posedge clk) begin
        if (reg_wr_en) begin
            tbmem[reg_addr[3:0]] <= reg_wdata;
            wr_cnt  = wr_cnt + 1;
            last_wa = reg_addr;
            last_wd = reg_wdata;
        end
        if (reg_rd_en) rd_cnt = rd_cnt + 1;
    end

    hbs_slave #(.REVISION(REV)) dut (
        .clk(clk), .rst(rst), .hb_cs_n(hb_cs_n), .hb_wr_n(hb_wr_n),
        .hb_rd_n(hb_rd_n), .hb_sel(hb_sel), .hb_data(hb_data),
        .hb_rdy_n(hb_rdy_n), .hb_int_n(hb_int_n), .hb_rst_n(hb_rst_n),
        .irq_req(irq_req), .periph_rst(periph_rst), .reg_addr(reg_addr),
        .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rd_en(reg_rd_en),
        .reg_rdata(reg_rdata)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic bit writable(input int a);
        return (a < 16) && (a inside {0, 1, 4, 5, 6, 7, 8, 9, 10, 12, 13});
    endfunction

    task automatic host_write(input logic cs_lvl, input logic sel, input logic [7:0] v,
                              output bit acked);
        hb_cs_n = cs_lvl; hb_sel = sel; drv = v; drv_en = 1'b1; hb_wr_n = 1'b0;
        repeat (4) step();
        hb_wr_n = 1'b1;
        acked = 1'b0;
        for (int i = 0; i < 12 && !acked; i++) begin
            step();
            if (!hb_rdy_n) acked = 1'b1;
        end
        if (acked) begin
            step();
            chk(hb_rdy_n == 1'b1, "R8 write ready lasts one cycle", hb_rdy_n, 1);
        end
        hb_cs_n = 1'b1; drv_en = 1'b0; hb_sel = 1'b0;
        repeat (3) step();
    endtask

    task automatic host_read(output logic [7:0] v, output bit acked);
        hb_cs_n = 1'b0; hb_sel = 1'b0; hb_rd_n = 1'b0;
        acked = 1'b0; v = 8'h00;
        for (int i = 0; i < 14 && !acked; i++) begin
            step();
            if (!hb_rdy_n) begin acked = 1'b1; v = hb_data; end
        end
        if (acked) begin
            step();
            chk(hb_rdy_n == 1'b1, "R8 read ready lasts one cycle", hb_rdy_n, 1);
        end
        hb_rd_n = 1'b1; hb_cs_n = 1'b1;
        repeat (3) step();
    endtask

    task automatic run_all();
        bit         ack;
        logic [7:0] rv;
        int         w0, r0;

        for (int i = 0; i < 16; i++) tbmem[i] = 8'h80 | 8'(i);
        repeat (3) step();
        // R1: reset state
        chk(hb_rdy_n == 1'b1, "R1 rdy idle in reset", hb_rdy_n, 1);
        chk(hb_int_n == 1'b1, "R1 int idle in reset", hb_int_n, 1);
        chk(periph_rst == 1'b0, "R1 periph_rst low in reset", periph_rst, 0);
        chk(reg_wr_en == 1'b0 && reg_rd_en == 1'b0, "R1 no enables in reset",
            {reg_wr_en, reg_rd_en}, 0);
        chk(hb_data == 8'hFF, "R1 bus undriven in reset", hb_data, 8'hFF);
        rst = 1'b0;
        step();
        chk(hb_rdy_n == 1'b1 && hb_data == 8'hFF, "R1 idle after reset", hb_data, 8'hFF);

        // Sweep every address: R2, R3, R4, R5, R6, R7, R8
        for (int a = 0; a < 256; a++) begin
            logic [7:0] pat;
            logic [7:0] exp;
            pat = 8'(a) ^ 8'h5A;
            w0 = wr_cnt;
            host_write(1'b0, 1'b1, 8'(a), ack);
            chk(ack, "R8 address write acknowledged", ack, 1);
            chk(wr_cnt == w0 && reg_addr == 8'(a), "R2 address latched, no write",
                reg_addr, a);
            w0 = wr_cnt;
            host_write(1'b0, 1'b0, pat, ack);
            chk(ack, "R4 data write acknowledged", ack, 1);
            if (writable(a))
                chk(wr_cnt == w0 + 1 && last_wa == 8'(a) && last_wd == pat,
                    "R3 one register write with latched addr and data", last_wd, pat);
            else
                chk(wr_cnt == w0, "R4 no write to revision or unmapped", wr_cnt - w0, 0);
            r0 = rd_cnt;
            host_read(rv, ack);
            chk(ack, "R8 read acknowledged", ack, 1);
            if (writable(a)) exp = pat;
            else if (a == 15) exp = REV;
            else exp = 8'h00;
            if (writable(a))
                chk(rv == exp && rd_cnt == r0 + 1, "R5 read returns register", rv, exp);
            else if (a == 15)
                chk(rv == exp && rd_cnt == r0, "R6 revision read", rv, exp);
            else
                chk(rv == exp && rd_cnt == r0, "R7 unmapped reads zero", rv, exp);
        end

        // R13: burst at one latched address
        host_write(1'b0, 1'b1, 8'h05, ack);
        host_write(1'b0, 1'b0, 8'h11, ack);
        chk(last_wa == 8'h05 && last_wd == 8'h11, "R13 first burst write", last_wd, 8'h11);
        host_write(1'b0, 1'b0, 8'h22, ack);
        chk(last_wa == 8'h05 && last_wd == 8'h22, "R13 second burst write", last_wa, 8'h05);
        host_read(rv, ack);
        chk(rv == 8'h22, "R13 first burst read", rv, 8'h22);
        host_read(rv, ack);
        chk(rv == 8'h22, "R13 second burst read", rv, 8'h22);

        // R10: strobes with chip select high are ignored
        host_write(1'b0, 1'b1, 8'h06, ack);
        host_write(1'b0, 1'b0, 8'h33, ack);
        w0 = wr_cnt;
        host_write(1'b1, 1'b1, 8'h00, ack);
        chk(!ack, "R10 no ready for deselected address write", ack, 0);
        chk(reg_addr == 8'h06, "R10 address latch unchanged", reg_addr, 8'h06);
        host_write(1'b1, 1'b0, 8'h99, ack);
        chk(!ack && wr_cnt == w0, "R10 deselected data write ignored", wr_cnt - w0, 0);
        host_read(rv, ack);
        chk(rv == 8'h33, "R10 register content unchanged", rv, 8'h33);

        // R9: read strobe in address phase leaves bus undriven
        r0 = rd_cnt;
        hb_cs_n = 1'b0; hb_sel = 1'b1; hb_rd_n = 1'b0;
        for (int i = 0; i < 8; i++) begin
            step();
            chk(hb_data == 8'hFF && hb_rdy_n == 1'b1, "R9 address-phase read not driven",
                hb_data, 8'hFF);
        end
        hb_rd_n = 1'b1; hb_cs_n = 1'b1; hb_sel = 1'b0;
        repeat (3) step();
        chk(rd_cnt == r0 && reg_addr == 8'h06, "R9 no fetch, address kept", reg_addr, 8'h06);
        chk(hb_data == 8'hFF, "R9 bus released after read", hb_data, 8'hFF);

        // R11: interrupt pass-through
        irq_req = 1'b1;
        step();
        chk(hb_int_n == 1'b0, "R11 interrupt asserted", hb_int_n, 0);
        irq_req = 1'b0;
        step();
        chk(hb_int_n == 1'b1, "R11 interrupt released", hb_int_n, 1);

        // R12: reset pass-through through the synchroniser
        hb_rst_n = 1'b0;
        step();
        chk(periph_rst == 1'b0, "R12 reset not yet through synchroniser", periph_rst, 0);
        step();
        chk(periph_rst == 1'b1, "R12 reset asserted", periph_rst, 1);
        hb_rst_n = 1'b1;
        repeat (2) step();
        chk(periph_rst == 1'b0, "R12 reset released", periph_rst, 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog expired actual=1 expected=0");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule